// File: doc/BRIEF.md
# Per-Core Auto-Advancing Compare Unit

This block watches a free-running 64-bit timebase that lives elsewhere in the chip and raises a per-core event when the count has reached a programmed 64-bit threshold. Each core gets its own copy. The copy holds the threshold, a 32-bit step size, three core-private control bits and a sticky event flag. The match is "count at or above threshold", not strict equality, so an event cannot be missed when the threshold is set into the past.

When the auto-advance mode is on, each event moves the threshold forward by the step size. This turns the unit into a periodic tick source without any software work between ticks. The interrupt line is the event flag gated by a core-private interrupt enable. Software clears the flag by writing a one to it. The global timer-enable bit comes in as an input, because it is shared by all cores and belongs to the counter.

Registers sit at these byte offsets: control 0x08, status 0x0C, threshold low word 0x10, threshold high word 0x14, step 0x18. Writes use a single-cycle strobe. Reads are combinational from a separate read address.

Top module: `cmp_autoinc_unit`

## Requirements
- R1: After reset, the control bits, the status flag, the 64-bit threshold and the step all read 0, and `irq_o` is 0.
- R2: An event happens in a cycle only when `timer_en_i` is 1, control bit 1 (compare enable) is 1, and `timebase_i` is greater than or equal to the threshold as unsigned numbers. Equality counts as a match.
- R3: An event sets status bit 0 on the next clock edge. The bit then stays 1 until software clears it, even when the count falls below the threshold or the enables drop.
- R4: When control bit 3 (auto-advance) is 1, each event adds the zero-extended 32-bit step to the threshold, modulo 2^64. At most one step is applied per cycle, so a threshold far behind the count catches up over successive cycles, with an event on each of them.
- R5: A write to offset 0x0C clears status bit 0 only if data bit 0 is 1. Writing 0 leaves the flag unchanged.
- R6: If an event and a clearing status write fall in the same cycle, the flag stays 1.
- R7: `irq_o` equals status bit 0 ANDed with control bit 2 (interrupt enable), in every cycle.
- R8: The threshold is written and read as two 32-bit halves at 0x10 (bits 31:0) and 0x14 (bits 63:32). The step is at 0x18. A control read at 0x08 returns bits 3..1 as written and bit 0 as `timer_en_i`. Any other read returns 0.
- R9: A software write to either threshold half in the same cycle as an auto-advance step takes effect, and the step is dropped for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timebase_i | input | 64 | Shared timebase count |
| timer_en_i | input | 1 | Shared timer enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 5 | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Per-core interrupt |

## Verification
The main function is exercised in five ways:
- Counts just below, exactly at and above the threshold, which separates a greater-or-equal match from equality or strict greater-than.
- Each enable dropped in turn, which shows that every gate is needed.
- A threshold set well behind the count with auto-advance on, which shows the one-step-per-cycle catch-up and that the flag is set again on each step.
- Collisions between an event and a clear, and between an event and a threshold write, which pin down the chosen priorities.
- A threshold near 2^64 with a step that wraps, which checks the modulo addition.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int CNT_W  = 64;
  localparam int DATA_W = 32;
  localparam int INC_W  = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMPL = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CMPH = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_STEP = 5'h18;

  typedef struct packed {
    logic auto_adv;   // bit 3
    logic irq_en;     // bit 2
    logic cmp_en;     // bit 1
  } core_ctl_t;

  function automatic logic cmp_reached(input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] thr);
    return cnt >= thr;
  endfunction

  function automatic logic [CNT_W-1:0] cmp_advance(input logic [CNT_W-1:0] thr,
                                                   input logic [INC_W-1:0] step);
    return thr + {{(CNT_W-INC_W){1'b0}}, step};
  endfunction

  function automatic logic [CNT_W-1:0] put_half(input logic [CNT_W-1:0] old,
                                                input logic hi,
                                                input logic [DATA_W-1:0] d);
    logic [CNT_W-1:0] r;
    r = old;
    if (hi) r[CNT_W-1:DATA_W] = d;
    else    r[DATA_W-1:0]     = d;
    return r;
  endfunction
endpackage

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output core_ctl_t         ctl_o,
  output logic [INC_W-1:0]  step_o,
  output logic              thr_lo_we_o,
  output logic              thr_hi_we_o,
  output logic              stat_clr_o
);
  core_ctl_t        ctl_q;
  logic [INC_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      step_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == OFS_CTRL) ctl_q  <= core_ctl_t'(wr_data_i[3:1]);
      if (wr_addr_i == OFS_STEP) step_q <= wr_data_i[INC_W-1:0];
    end
  end

  assign ctl_o       = ctl_q;
  assign step_o      = step_q;
  assign thr_lo_we_o = wr_en_i && (wr_addr_i == OFS_CMPL);
  assign thr_hi_we_o = wr_en_i && (wr_addr_i == OFS_CMPH);
  assign stat_clr_o  = wr_en_i && (wr_addr_i == OFS_STAT) && wr_data_i[0];
endmodule

// File: rtl/cmp_engine.sv
module cmp_engine
  import cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  timebase_i,
  input  logic              timer_en_i,
  input  core_ctl_t         ctl_i,
  input  logic [INC_W-1:0]  step_i,
  input  logic              thr_lo_we_i,
  input  logic              thr_hi_we_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_clr_i,
  output logic [CNT_W-1:0]  thr_o,
  output logic              stat_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] thr_q, thr_d;
  logic             stat_q;
  logic             hit_evt;
  logic             adv_evt;
  logic             sw_thr_wr;

  assign hit_evt   = timer_en_i && ctl_i.cmp_en && cmp_reached(timebase_i, thr_q);
  assign sw_thr_wr = thr_lo_we_i || thr_hi_we_i;
  assign adv_evt   = hit_evt && ctl_i.auto_adv && !sw_thr_wr;

  always_comb begin
    thr_d = thr_q;
    if (sw_thr_wr)    thr_d = put_half(thr_q, thr_hi_we_i, wr_data_i);
    else if (adv_evt) thr_d = cmp_advance(thr_q, step_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      thr_q <= thr_d;
      if (hit_evt)         stat_q <= 1'b1;
      else if (stat_clr_i) stat_q <= 1'b0;
    end
  end

  assign thr_o  = thr_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q && ctl_i.irq_en;

  // R3
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_evt |=> stat_q);
  // R6
  event_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_evt && stat_clr_i) |=> stat_q);
  // R5
  clear_works_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !hit_evt) |=> !stat_q);
  // R3
  flag_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_evt && !stat_clr_i) |=> (stat_q == $past(stat_q)));
  // R4
  step_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_evt |=> (thr_q == $past(thr_q) + {{(CNT_W-INC_W){1'b0}}, $past(step_i)}));
  // R2
  no_event_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!timer_en_i || !ctl_i.cmp_en) |-> !hit_evt);
  // R9
  sw_write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_lo_we_i |=> (thr_q[DATA_W-1:0] == $past(wr_data_i)));
endmodule

// File: rtl/cmp_autoinc_unit.sv
module cmp_autoinc_unit
  import cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       timebase_i,
  input  logic              timer_en_i,
  input  logic              wr_en_i,
  input  logic [4:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [4:0]        rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  core_ctl_t        ctl;
  logic [INC_W-1:0] step;
  logic             thr_lo_we, thr_hi_we, stat_clr;
  logic [CNT_W-1:0] thr;
  logic             stat;

  cmp_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .ctl_o(ctl), .step_o(step),
    .thr_lo_we_o(thr_lo_we), .thr_hi_we_o(thr_hi_we), .stat_clr_o(stat_clr)
  );

  cmp_engine u_engine (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .timebase_i(timebase_i), .timer_en_i(timer_en_i),
    .ctl_i(ctl), .step_i(step),
    .thr_lo_we_i(thr_lo_we), .thr_hi_we_i(thr_hi_we),
    .wr_data_i(wr_data_i), .stat_clr_i(stat_clr),
    .thr_o(thr), .stat_o(stat), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      OFS_CTRL: rd_data_o = {28'd0, ctl, timer_en_i};
      OFS_STAT: rd_data_o = {31'd0, stat};
      OFS_CMPL: rd_data_o = thr[DATA_W-1:0];
      OFS_CMPH: rd_data_o = thr[CNT_W-1:DATA_W];
      OFS_STEP: rd_data_o = step;
      default:  rd_data_o = '0;
    endcase
  end

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctl.irq_en && stat));
endmodule

// File: tb/cmp_autoinc_unit_test.sv
`timescale 1ns/100ps
module cmp_autoinc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] tb_cnt = '0;
  logic        ten = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  wa = '0;
  logic [31:0] wd = '0;
  logic [4:0]  ra = '0;
  logic [31:0] rd;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  longint unsigned m_thr = 0;
  int unsigned     m_step = 0;
  bit m_cen = 0, m_ien = 0, m_auto = 0, m_flag = 0;

  always #2 clk = ~clk;  // 250 MHz

  cmp_autoinc_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .timebase_i(tb_cnt), .timer_en_i(ten),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
  );

  task automatic check(input string req, input string what,
                       input longint unsigned got, input longint unsigned exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // reference: state change at one clock edge, from values held before it
  task automatic model_edge();
    bit hit;
    hit = ten && m_cen && (tb_cnt >= m_thr);
    if (hit) m_flag = 1;
    else if (we && wa == 5'h0C && wd[0]) m_flag = 0;
    if (we && wa == 5'h10)      m_thr = {m_thr[63:32], wd};
    else if (we && wa == 5'h14) m_thr = {wd, m_thr[31:0]};
    else if (hit && m_auto)     m_thr = m_thr + m_step;
    if (we && wa == 5'h08) begin
      m_cen = wd[1]; m_ien = wd[2]; m_auto = wd[3];
    end
    if (we && wa == 5'h18) m_step = wd;
  endtask

  task automatic peek(input string req);
    ra = 5'h08; #0.2 check(req, "ctrl", rd, {28'd0, m_auto, m_ien, m_cen, ten});
    ra = 5'h0C; #0.2 check(req, "status", rd, m_flag);
    ra = 5'h10; #0.2 check(req, "thr_lo", rd, m_thr[31:0]);
    ra = 5'h14; #0.2 check(req, "thr_hi", rd, m_thr[63:32]);
    ra = 5'h18; #0.2 check(req, "step", rd, m_step);
    ra = 5'h1C; #0.2 check(req, "unmapped", rd, 0);
    check(req, "irq", irq, m_flag && m_ien);
  endtask

  // one cycle: inputs set at negedge, edge modelled, outputs checked at next negedge
  task automatic step(input string req, input bit w, input logic [4:0] a,
                      input logic [31:0] d);
    we = w; wa = a; wd = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    we = 0;
    peek(req);
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) step(req, 0, 5'h00, 0);
  endtask

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    peek("R1");
    rst_n = 1'b1;
    @(negedge clk);
    peek("R1");

    // R8: register access
    step("R8", 1, 5'h10, 32'd100);
    step("R8", 1, 5'h14, 32'd0);
    step("R8", 1, 5'h18, 32'hDEAD_0001);
    step("R8", 1, 5'h18, 32'd0);
    step("R8", 1, 5'h08, 32'h0000_0006);   // cmp_en + irq_en

    // R2: timer disabled blocks the event
    tb_cnt = 64'd200; ten = 0;
    idle("R2", 2);
    // R2: count below, at threshold
    ten = 1; tb_cnt = 64'd99;
    idle("R2", 2);
    tb_cnt = 64'd100;
    idle("R2", 1);
    // R3: sticky after count falls
    tb_cnt = 64'd50;
    idle("R3", 2);
    // R5: write 0 no effect, write 1 clears; R7 irq follows
    step("R5", 1, 5'h0C, 32'h0);
    step("R5", 1, 5'h0C, 32'h1);
    // R2: compare enable off
    step("R2", 1, 5'h08, 32'h0000_0004);
    tb_cnt = 64'd500;
    idle("R2", 2);

    // R4: catch-up, one step per cycle
    step("R4", 1, 5'h18, 32'd10);
    step("R4", 1, 5'h08, 32'h0000_000E);
    tb_cnt = 64'd135;
    idle("R4", 6);
    step("R5", 1, 5'h0C, 32'h1);
    idle("R4", 2);

    // R6: clear colliding with event
    tb_cnt = 64'd1000;
    idle("R6", 1);
    step("R6", 1, 5'h0C, 32'h1);
    // R7: interrupt enable off leaves flag but no irq
    step("R7", 1, 5'h08, 32'h0000_000A);
    idle("R7", 2);
    // R9: threshold write beats auto step
    step("R9", 1, 5'h10, 32'd5);
    step("R9", 1, 5'h14, 32'd0);
    idle("R9", 1);

    // R4: wrap modulo 2^64
    tb_cnt = 64'hFFFF_FFFF_FFFF_FFFF;
    step("R4", 1, 5'h18, 32'h20);
    step("R4", 1, 5'h14, 32'hFFFF_FFFF);
    step("R4", 1, 5'h10, 32'hFFFF_FFF0);
    idle("R4", 3);
    ten = 0;
    idle("R2", 2);

    // R1: reset mid-run
    rst_n = 1'b0;
    m_thr = 0; m_step = 0; m_cen = 0; m_ien = 0; m_auto = 0; m_flag = 0;
    #1 peek("R1");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule